// File: doc/BRIEF.md
# Microcoded Multicycle Control Sequencer

This block drives the control lines of a multicycle datapath from a small microprogram instead of a hand-built next-state network. A 4-bit microaddress register selects one word of a 12-word control store. Each word carries every datapath strobe and selector plus a 2-bit sequencing code. That code tells the address-select logic where the next microaddress comes from: address zero, the current address plus one, or one of two lookup tables indexed by the 6-bit instruction opcode.

The datapath places the opcode of the fetched instruction on the `opcode` input. The sequencer steps through fetch and decode. It then branches into the routine for that instruction class and returns to fetch when the routine is done. The microaddress is also brought out, so that the path taken through the microprogram can be observed.

Top module: `useq_ctrl`

## Requirements
- R1: A synchronous active-high reset forces the microaddress to 0 on the next rising edge. At address 0 the word drives `pc_wr`=1, `ir_wr`=1 and `alu_op`=0 (add).
- R2: Sequencing code 2'b11 loads the current address plus one. Code 2'b00 loads address 0. The code stored at addresses 0 to 11 is, in order: 11, 01, 10, 11, 00, 00, 11, 00, 00, 00, 11, 00.
- R3: Code 2'b01 loads from the first table. Opcode 000000 (register ALU) gives 6, 000010 (jump) gives 9, 000100 (branch-equal) gives 8, 001011 (or-immediate) gives 10, and 100011 (load) and 101011 (store) both give 2.
- R4: Code 2'b10 loads from the second table. Load gives 3 and store gives 5. The opcode is sampled in the cycle the code is applied.
- R5: An opcode that is absent from the table being consulted yields address 0.
- R6: Each instruction visits its microaddress path and then returns to 0. Load takes 0,1,2,3,4. Store takes 0,1,2,5. Register ALU takes 0,1,6,7. Branch-equal takes 0,1,8. Jump takes 0,1,9. Or-immediate takes 0,1,10,11.
- R7: The control fields depend on the microaddress only. `alu_op` is encoded 0 add, 1 subtract, 2 or, 3 function-field. `reg_wr` is 1 at addresses 4, 7 and 11. `mem_wr` is 1 at 5. `pc_wr_cond`=1 with subtract at 8. `pc_wr`=1 at 0 and 9. `ir_wr`=1 at 0. `alu_op` is or at 10 and 11, and function-field at 6 and 7.
- R8: `mem_wr` is never asserted outside address 5, and `reg_wr` never outside addresses 4, 7 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode of the current instruction |
| upc_addr | output | 4 | Current microaddress |
| pc_wr | output | 1 | Unconditional program counter write |
| pc_wr_cond | output | 1 | Program counter write when ALU result is zero |
| ir_wr | output | 1 | Instruction register write |
| br_wr | output | 1 | Branch target register write |
| mem_wr | output | 1 | Memory write |
| adr_sel | output | 1 | Memory address from ALU result (1) or program counter (0) |
| reg_wr | output | 1 | Register file write |
| reg_dst | output | 1 | Destination from rd (1) or rt (0) |
| mem_to_reg | output | 1 | Register write data from memory (1) or ALU (0) |
| ext_op | output | 1 | Sign-extend (1) or zero-extend (0) immediate |
| alu_sel_a | output | 1 | ALU A from register (1) or program counter (0) |
| alu_sel_b | output | 2 | ALU B source select |
| alu_op | output | 2 | ALU operation: 0 add, 1 sub, 2 or, 3 function-field |
| pc_src | output | 2 | PC source: 0 ALU, 1 branch target, 2 jump |
| seq_sel | output | 2 | Sequencing code of the current word |

## Verification
The bench builds the block with the default parameters: a 4-bit microaddress, a 6-bit opcode and 12 control words. With these values every stored word is reachable, along with all six instruction routines and both tables. An opcode outside the six known ones is also exercised. Opcodes are changed between the decode step and the second dispatch, which shows that each table is read with the opcode present at that moment. A reset is also applied in the middle of a routine.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int OP_W      = 6;
    localparam int ADDR_W    = 4;
    localparam int NUM_WORDS = 12;

    typedef enum logic [1:0] {
        SEQ_ZERO  = 2'b00,
        SEQ_DISP1 = 2'b01,
        SEQ_DISP2 = 2'b10,
        SEQ_NEXT  = 2'b11
    } seq_e;

    typedef enum logic [1:0] {
        ALU_ADD   = 2'd0,
        ALU_SUB   = 2'd1,
        ALU_OR    = 2'd2,
        ALU_FUNCT = 2'd3
    } alu_e;

    typedef enum logic [1:0] {
        PC_FROM_ALU    = 2'd0,
        PC_FROM_TARGET = 2'd1,
        PC_FROM_JUMP   = 2'd2,
        PC_RSVD        = 2'd3
    } pcsrc_e;

    typedef struct packed {
        logic       pc_wr;
        logic       pc_wr_cond;
        logic       ir_wr;
        logic       br_wr;
        logic       mem_wr;
        logic       adr_sel;
        logic       reg_wr;
        logic       reg_dst;
        logic       mem_to_reg;
        logic       ext_op;
        logic       alu_sel_a;
        logic [1:0] alu_sel_b;
        alu_e       alu_op;
        pcsrc_e     pc_src;
    } dp_ctl_t;

    typedef struct packed {
        dp_ctl_t dp;
        seq_e    seq;
    } uword_t;

    localparam logic [OP_W-1:0] OP_RALU = 6'b000000;
    localparam logic [OP_W-1:0] OP_JMP  = 6'b000010;
    localparam logic [OP_W-1:0] OP_BEQ  = 6'b000100;
    localparam logic [OP_W-1:0] OP_ORI  = 6'b001011;
    localparam logic [OP_W-1:0] OP_LD   = 6'b100011;
    localparam logic [OP_W-1:0] OP_ST   = 6'b101011;

    localparam logic [ADDR_W-1:0] ST_FETCH  = 4'd0;
    localparam logic [ADDR_W-1:0] ST_DECODE = 4'd1;
    localparam logic [ADDR_W-1:0] ST_ADDR   = 4'd2;
    localparam logic [ADDR_W-1:0] ST_LD_MEM = 4'd3;
    localparam logic [ADDR_W-1:0] ST_LD_WB  = 4'd4;
    localparam logic [ADDR_W-1:0] ST_ST_MEM = 4'd5;
    localparam logic [ADDR_W-1:0] ST_R_EXE  = 4'd6;
    localparam logic [ADDR_W-1:0] ST_R_WB   = 4'd7;
    localparam logic [ADDR_W-1:0] ST_BR     = 4'd8;
    localparam logic [ADDR_W-1:0] ST_JUMP   = 4'd9;
    localparam logic [ADDR_W-1:0] ST_OI_EXE = 4'd10;
    localparam logic [ADDR_W-1:0] ST_OI_WB  = 4'd11;

    function automatic logic known_op(input logic [OP_W-1:0] op);
        return (op == OP_RALU) || (op == OP_JMP) || (op == OP_BEQ) ||
               (op == OP_ORI)  || (op == OP_LD)  || (op == OP_ST);
    endfunction

    function automatic uword_t uword_at(input logic [ADDR_W-1:0] a);
        uword_t w;
        w = '0;
        unique case (a)
            ST_FETCH: begin
                w.dp.pc_wr = 1'b1; w.dp.ir_wr = 1'b1;
                w.seq = SEQ_NEXT;
            end
            ST_DECODE: begin
                w.dp.br_wr = 1'b1; w.dp.ext_op = 1'b1;
                w.dp.alu_sel_b = 2'b10;
                w.seq = SEQ_DISP1;
            end
            ST_ADDR: begin
                w.dp.ext_op = 1'b1; w.dp.alu_sel_a = 1'b1;
                w.dp.alu_sel_b = 2'b11;
                w.seq = SEQ_DISP2;
            end
            ST_LD_MEM: begin
                w.dp.ext_op = 1'b1; w.dp.alu_sel_a = 1'b1;
                w.dp.alu_sel_b = 2'b11; w.dp.adr_sel = 1'b1;
                w.seq = SEQ_NEXT;
            end
            ST_LD_WB: begin
                w.dp.ext_op = 1'b1; w.dp.alu_sel_a = 1'b1;
                w.dp.alu_sel_b = 2'b11; w.dp.mem_to_reg = 1'b1;
                w.dp.reg_wr = 1'b1;
                w.seq = SEQ_ZERO;
            end
            ST_ST_MEM: begin
                w.dp.ext_op = 1'b1; w.dp.alu_sel_a = 1'b1;
                w.dp.alu_sel_b = 2'b11; w.dp.mem_wr = 1'b1;
                w.dp.adr_sel = 1'b1;
                w.seq = SEQ_ZERO;
            end
            ST_R_EXE: begin
                w.dp.reg_dst = 1'b1; w.dp.alu_sel_a = 1'b1;
                w.dp.alu_sel_b = 2'b01; w.dp.alu_op = ALU_FUNCT;
                w.seq = SEQ_NEXT;
            end
            ST_R_WB: begin
                w.dp.reg_dst = 1'b1; w.dp.alu_sel_a = 1'b1;
                w.dp.alu_sel_b = 2'b01; w.dp.alu_op = ALU_FUNCT;
                w.dp.reg_wr = 1'b1;
                w.seq = SEQ_ZERO;
            end
            ST_BR: begin
                w.dp.pc_wr_cond = 1'b1; w.dp.alu_sel_a = 1'b1;
                w.dp.alu_sel_b = 2'b01; w.dp.alu_op = ALU_SUB;
                w.dp.pc_src = PC_FROM_TARGET;
                w.seq = SEQ_ZERO;
            end
            ST_JUMP: begin
                w.dp.pc_wr = 1'b1; w.dp.pc_src = PC_FROM_JUMP;
                w.seq = SEQ_ZERO;
            end
            ST_OI_EXE: begin
                w.dp.alu_sel_a = 1'b1; w.dp.alu_sel_b = 2'b11;
                w.dp.alu_op = ALU_OR;
                w.seq = SEQ_NEXT;
            end
            ST_OI_WB: begin
                w.dp.alu_sel_a = 1'b1; w.dp.alu_sel_b = 2'b11;
                w.dp.alu_op = ALU_OR; w.dp.reg_wr = 1'b1;
                w.seq = SEQ_ZERO;
            end
            default: w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int WORDS = NUM_WORDS
) (
    input  logic [AW-1:0] addr,
    output uword_t        word
);
    uword_t rom [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        assign rom[g] = uword_at(ADDR_W'(g));
    end

    always_comb begin
        if (int'(addr) < WORDS) word = rom[addr];
        else                    word = '0;
    end
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
    import useq_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int OW = OP_W
) (
    input  logic [OW-1:0] opcode,
    output logic [AW-1:0] tgt1,
    output logic [AW-1:0] tgt2
);
    always_comb begin
        unique case (opcode)
            OP_RALU: tgt1 = AW'(ST_R_EXE);
            OP_JMP:  tgt1 = AW'(ST_JUMP);
            OP_BEQ:  tgt1 = AW'(ST_BR);
            OP_ORI:  tgt1 = AW'(ST_OI_EXE);
            OP_LD:   tgt1 = AW'(ST_ADDR);
            OP_ST:   tgt1 = AW'(ST_ADDR);
            default: tgt1 = '0;
        endcase
    end

    always_comb begin
        unique case (opcode)
            OP_LD:   tgt2 = AW'(ST_LD_MEM);
            OP_ST:   tgt2 = AW'(ST_ST_MEM);
            default: tgt2 = '0;
        endcase
    end
endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  seq_e          sel,
    input  logic [AW-1:0] tgt1,
    input  logic [AW-1:0] tgt2,
    output logic [AW-1:0] cur
);
    logic [AW-1:0] nxt;

    always_comb begin
        unique case (sel)
            SEQ_ZERO:  nxt = '0;
            SEQ_DISP1: nxt = tgt1;
            SEQ_DISP2: nxt = tgt2;
            SEQ_NEXT:  nxt = cur + 1'b1;
            default:   nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assert_reset_zero_R1: assert property (@(posedge clk) rst |=> cur == '0);
    assert_go_zero_R2: assert property (@(posedge clk) disable iff (rst)
        sel == SEQ_ZERO |=> cur == '0);
    assert_increment_R2: assert property (@(posedge clk) disable iff (rst)
        sel == SEQ_NEXT |=> cur == AW'($past(cur) + 1'b1));
    assert_table1_R3: assert property (@(posedge clk) disable iff (rst)
        sel == SEQ_DISP1 |=> cur == $past(tgt1));
    assert_table2_R4: assert property (@(posedge clk) disable iff (rst)
        sel == SEQ_DISP2 |=> cur == $past(tgt2));
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int OW    = OP_W,
    parameter int WORDS = NUM_WORDS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [OW-1:0] opcode,
    output logic [AW-1:0] upc_addr,
    output logic          pc_wr,
    output logic          pc_wr_cond,
    output logic          ir_wr,
    output logic          br_wr,
    output logic          mem_wr,
    output logic          adr_sel,
    output logic          reg_wr,
    output logic          reg_dst,
    output logic          mem_to_reg,
    output logic          ext_op,
    output logic          alu_sel_a,
    output logic [1:0]    alu_sel_b,
    output logic [1:0]    alu_op,
    output logic [1:0]    pc_src,
    output logic [1:0]    seq_sel
);
    uword_t        word;
    logic [AW-1:0] upc, tgt1, tgt2;

    useq_store #(.AW(AW), .WORDS(WORDS)) u_store (.addr(upc), .word(word));

    useq_dispatch #(.AW(AW), .OW(OW)) u_disp (
        .opcode(opcode), .tgt1(tgt1), .tgt2(tgt2));

    useq_next #(.AW(AW)) u_next (
        .clk(clk), .rst(rst), .sel(word.seq),
        .tgt1(tgt1), .tgt2(tgt2), .cur(upc));

    assign upc_addr   = upc;
    assign pc_wr      = word.dp.pc_wr;
    assign pc_wr_cond = word.dp.pc_wr_cond;
    assign ir_wr      = word.dp.ir_wr;
    assign br_wr      = word.dp.br_wr;
    assign mem_wr     = word.dp.mem_wr;
    assign adr_sel    = word.dp.adr_sel;
    assign reg_wr     = word.dp.reg_wr;
    assign reg_dst    = word.dp.reg_dst;
    assign mem_to_reg = word.dp.mem_to_reg;
    assign ext_op     = word.dp.ext_op;
    assign alu_sel_a  = word.dp.alu_sel_a;
    assign alu_sel_b  = word.dp.alu_sel_b;
    assign alu_op     = word.dp.alu_op;
    assign pc_src     = word.dp.pc_src;
    assign seq_sel    = word.seq;

    assert_unknown_restart_R5: assert property (@(posedge clk) disable iff (rst)
        (upc == AW'(ST_DECODE) && !known_op(opcode)) |=> upc == '0);
    assert_memwr_only_store_R8: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> upc == AW'(ST_ST_MEM));
    assert_regwr_only_wb_R8: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> (upc == AW'(ST_LD_WB) || upc == AW'(ST_R_WB) || upc == AW'(ST_OI_WB)));
    assert_fetch_loads_ir_R1: assert property (@(posedge clk) disable iff (rst)
        upc == '0 |-> (ir_wr && pc_wr));
endmodule

// File: tb/test_useq_ctrl.sv
module test_useq_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'b0;
    logic [3:0] upc_addr;
    logic pc_wr, pc_wr_cond, ir_wr, br_wr, mem_wr, adr_sel, reg_wr;
    logic reg_dst, mem_to_reg, ext_op, alu_sel_a;
    logic [1:0] alu_sel_b, alu_op, pc_src, seq_sel;

    useq_ctrl i_useq_ctrl (
        .clk(clk), .rst(rst), .opcode(opcode), .upc_addr(upc_addr),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .ir_wr(ir_wr), .br_wr(br_wr),
        .mem_wr(mem_wr), .adr_sel(adr_sel), .reg_wr(reg_wr), .reg_dst(reg_dst),
        .mem_to_reg(mem_to_reg), .ext_op(ext_op), .alu_sel_a(alu_sel_a),
        .alu_sel_b(alu_sel_b), .alu_op(alu_op), .pc_src(pc_src), .seq_sel(seq_sel));

    always #5 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    bit    reported = 0;
    int    expq[$];
    string tagq[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
        end
    endtask

    // R7: {pc_wr, ir_wr, mem_wr, reg_wr, alu_op} per microaddress
    function automatic logic [5:0] exp_ctl(input int s);
        case (s)
            0:  return 6'b110000;
            4:  return 6'b000100;
            5:  return 6'b001000;
            6:  return 6'b000011;
            7:  return 6'b000111;
            8:  return 6'b000001;
            9:  return 6'b100000;
            10: return 6'b000010;
            11: return 6'b000110;
            default: return 6'b000000;
        endcase
    endfunction

    // R2: sequencing code per microaddress
    function automatic logic [1:0] exp_seq(input int s);
        case (s)
            0, 3, 6, 10: return 2'b11;
            1:           return 2'b01;
            2:           return 2'b10;
            default:     return 2'b00;
        endcase
    endfunction

    // monitor: pop expected microaddress, compare address and control fields
    always @(negedge clk) begin
        if (!rst && expq.size() > 0) begin
            int    e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            chk(upc_addr == 4'(e), t, int'(upc_addr), e);
            chk({pc_wr, ir_wr, mem_wr, reg_wr, alu_op} == exp_ctl(e), "R7",
                int'({pc_wr, ir_wr, mem_wr, reg_wr, alu_op}), int'(exp_ctl(e)));
            chk(seq_sel == exp_seq(e), "R2", int'(seq_sel), int'(exp_seq(e)));
            if (e == 8) chk(pc_wr_cond == 1'b1, "R7", int'(pc_wr_cond), 1);
            if (e != 5) chk(mem_wr == 1'b0, "R8", int'(mem_wr), 0);
        end
    end

    // driver: called one step after a rising edge while the address is 0
    task automatic run_op(input logic [5:0] op, input string tag,
                          input int path [6], input int n);
        opcode = op;
        for (int i = 0; i < n; i++) begin
            expq.push_back(path[i]);
            tagq.push_back(tag);
        end
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    initial begin
        #100000;
        if (!reported) begin
            checks++;
            errors++;
            $display("FAIL watchdog R6 actual 0 expected 1");
            report();
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(upc_addr == 4'd0, "R1", int'(upc_addr), 0);
        chk(pc_wr && ir_wr && alu_op == 2'd0, "R1", int'({pc_wr, ir_wr, alu_op}), 12);
        step();
        rst = 1'b0;

        run_op(6'b100011, "R6 load",   '{0, 1, 2, 3, 4, 0}, 5);
        run_op(6'b101011, "R6 store",  '{0, 1, 2, 5, 0, 0}, 4);
        run_op(6'b000000, "R6 ralu",   '{0, 1, 6, 7, 0, 0}, 4);
        run_op(6'b000100, "R6 beq",    '{0, 1, 8, 0, 0, 0}, 3);
        run_op(6'b000010, "R6 jump",   '{0, 1, 9, 0, 0, 0}, 3);
        run_op(6'b001011, "R6 ori",    '{0, 1, 10, 11, 0, 0}, 4);
        run_op(6'b111111, "R5 unknown",'{0, 1, 0, 0, 0, 0}, 2);
        run_op(6'b000001, "R5 unknown",'{0, 1, 0, 0, 0, 0}, 2);
        run_op(6'b100011, "R3 load",   '{0, 1, 2, 3, 4, 0}, 5);

        // R5: opcode changes to one absent from table 2 before second dispatch
        opcode = 6'b100011;
        step();
        step();
        chk(upc_addr == 4'd2, "R3", int'(upc_addr), 2);
        opcode = 6'b000100;
        step();
        chk(upc_addr == 4'd0, "R5", int'(upc_addr), 0);

        // R4: load decodes to 2, store present at second dispatch goes to 5
        opcode = 6'b100011;
        step();
        step();
        opcode = 6'b101011;
        step();
        chk(upc_addr == 4'd5, "R4", int'(upc_addr), 5);
        chk(mem_wr == 1'b1, "R7", int'(mem_wr), 1);
        step();
        chk(upc_addr == 4'd0, "R2", int'(upc_addr), 0);

        // R1: reset in the middle of a routine
        opcode = 6'b001011;
        step();
        step();
        chk(upc_addr == 4'd10, "R3", int'(upc_addr), 10);
        step();
        chk(upc_addr == 4'd11, "R2", int'(upc_addr), 11);
        rst = 1'b1;
        step();
        chk(upc_addr == 4'd0, "R1", int'(upc_addr), 0);
        rst = 1'b0;

        run_op(6'b000000, "R6 ralu",   '{0, 1, 6, 7, 0, 0}, 4);
        @(negedge clk);
        report();
        $finish;
    end
endmodule